// File: doc/BRIEF.md
# Programmable Raster Timing Generator with Pixel Output

This block produces the horizontal and vertical timing of a progressive-scan display and the pixel stream that goes with it. Every line and every frame walk through four phases in a fixed order: front porch, sync pulse, back porch, then the visible span. The width of each phase is a static configuration input for each axis. Visible spans from 320x240 up to 1920x1200 and beyond fit the default counter widths. During visible pixels the block pulls 24-bit RGB words from the read side of a show-ahead FIFO. It drives them out together with a data-enable, a horizontal sync and a vertical sync. The horizontal sync pin can instead carry a composite sync.

Two optional modes change where pixels come from. The colour-bar mode replaces FIFO data with eight vertical bars generated inside the block and never reads the FIFO. The mirror mode fetches each line one line ahead into one half of a two-bank line store and plays it back right-to-left from the other half. A power-save input freezes the raster position and drives every output low. All outputs are registered and appear one clock after the raster position that produced them.

Top module: `raster_top`

## Requirements
- R1: Each line has (front+sync+back+visible) horizontal configuration clocks, counted from column 0 in that order. The raw horizontal sync is active for columns front through front+sync-1.
- R2: Each frame has (front+sync+back+visible) vertical configuration lines, in that order. The raw vertical sync is active for whole lines front through front+sync-1.
- R3: `deOut` is high exactly when both axes are in their visible phase. Every output reflects the raster position of the previous clock.
- R4: With both modes off, `fifoRd` is high exactly in visible columns of visible lines, and `rgbOut` shows the FIFO head word presented in that cycle. Red is in bits 23:16, green in 15:8 and blue in 7:0.
- R5: When a polarity bit is 1, that sync pin is high while its raw sync is active. When the bit is 0, the pin is low while its raw sync is active.
- R6: With composite mode on, `hSyncOut` is the XNOR of the two active-low raw syncs: it is low when exactly one raw sync is active, and `hSyncPol` is ignored. `vSyncOut` still follows R2 and R5.
- R7: In colour-bar mode, `fifoRd` stays low. Visible column c shows bar min(c / floor(visible/8), 7), so any leftover columns join the last bar. Bars 0..7 are white, yellow, cyan, green, magenta, red, blue, black, each component being 00 or FF.
- R8: In mirror mode, FIFO reads take place in the visible columns of the line before each visible line. Visible column c then shows the word read at column visible-1-c of that earlier line.
- R9: `rgbOut` is zero whenever `deOut` is low.
- R10: While `rst_n` is low, all outputs and `fifoRd` are low. Release starts the raster at column 0 of line 0, the first front-porch clock of the first front-porch line.
- R11: While `pwrSave` is high, `fifoRd` is low at once, the raster position holds, and all outputs are low from the next clock. After release the raster resumes from the held position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrSave | input | 1 | Freeze raster and force outputs low |
| testMode | input | 1 | Colour-bar source instead of FIFO |
| flipEn | input | 1 | Mirror each line horizontally |
| compSync | input | 1 | Put composite sync on hSyncOut |
| hSyncPol | input | 1 | 1 = horizontal sync active-high |
| vSyncPol | input | 1 | 1 = vertical sync active-high |
| hVisible | input | H_CNT_W | Visible columns per line |
| hFrontPorch | input | H_CNT_W | Horizontal front porch clocks |
| hSyncWidth | input | H_CNT_W | Horizontal sync clocks |
| hBackPorch | input | H_CNT_W | Horizontal back porch clocks |
| vVisible | input | V_CNT_W | Visible lines per frame |
| vFrontPorch | input | V_CNT_W | Vertical front porch lines |
| vSyncWidth | input | V_CNT_W | Vertical sync lines |
| vBackPorch | input | V_CNT_W | Vertical back porch lines |
| fifoRd | output | 1 | Consume FIFO head at this edge |
| fifoData | input | 3*COMP_W | FIFO head word (show-ahead) |
| rgbOut | output | 3*COMP_W | Registered pixel, R:G:B |
| hSyncOut | output | 1 | Horizontal or composite sync |
| vSyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data enable / not blanking |

## Verification
In mirror mode, two things happen in the same clock on every visible line except the last: the next line's FIFO word is written into one bank of the line store, and the current line is read back reversed from the other bank. A write that landed in the wrong bank, or a bank swap at the wrong edge, shows up as a pixel from the wrong line. The bench provokes this overlap by running two whole mirrored frames. It feeds the FIFO words whose values encode their global read index, so every pixel can be traced to exactly one fetch. Each visible pixel is judged against the index predicted from its frame, row and reversed column.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int BAR_COUNT = 8;
  localparam int BAR_IDX_W = $clog2(BAR_COUNT);

  // Strobes from the timing control to the pixel datapath.
  typedef struct packed {
    logic                 active;   // visible column on a visible line
    logic                 hRaw;     // horizontal sync interval, polarity-free
    logic                 vRaw;     // vertical sync interval, polarity-free
    logic                 fetch;    // FIFO word consumed this cycle
    logic                 lineEnd;  // last clock of a line (bank swap)
    logic [BAR_IDX_W-1:0] bar;      // colour-bar index of this column
  } strobe_t;

  // Component on/off mask {r,g,b} for each bar, left to right.
  function automatic logic [2:0] barMask(input logic [BAR_IDX_W-1:0] idx);
    logic [2:0] m;
    case (idx)
      3'd0:    m = 3'b111;  // white
      3'd1:    m = 3'b110;  // yellow
      3'd2:    m = 3'b011;  // cyan
      3'd3:    m = 3'b010;  // green
      3'd4:    m = 3'b101;  // magenta
      3'd5:    m = 3'b100;  // red
      3'd6:    m = 3'b001;  // blue
      default: m = 3'b000;  // black
    endcase
    return m;
  endfunction

endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int H_CNT_W = 12,
  parameter int V_CNT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwrSave,
  input  logic               testMode,
  input  logic               flipEn,
  input  logic [H_CNT_W-1:0] hVisible,
  input  logic [H_CNT_W-1:0] hFrontPorch,
  input  logic [H_CNT_W-1:0] hSyncWidth,
  input  logic [H_CNT_W-1:0] hBackPorch,
  input  logic [V_CNT_W-1:0] vVisible,
  input  logic [V_CNT_W-1:0] vFrontPorch,
  input  logic [V_CNT_W-1:0] vSyncWidth,
  input  logic [V_CNT_W-1:0] vBackPorch,
  output strobe_t            stb,
  output logic [H_CNT_W-1:0] col,
  output logic               fifoRd
);

  logic [H_CNT_W-1:0]   hCount, hSyncEnd, hActStart, hLastCol, barCnt, barWidth;
  logic [V_CNT_W-1:0]   vCount, vSyncEnd, vActStart, vLastRow;
  logic [BAR_IDX_W-1:0] barIdx;
  logic                 hLast, vLast, actCol, actRow, preRow, fetchRow, fetchOn;

  // phase boundaries, in order front porch, sync, back porch, visible
  assign hSyncEnd  = hFrontPorch + hSyncWidth;
  assign hActStart = hSyncEnd + hBackPorch;
  assign hLastCol  = hActStart + hVisible - 1'b1;
  assign vSyncEnd  = vFrontPorch + vSyncWidth;
  assign vActStart = vSyncEnd + vBackPorch;
  assign vLastRow  = vActStart + vVisible - 1'b1;
  assign barWidth  = hVisible >> BAR_IDX_W;

  assign hLast  = (hCount == hLastCol);
  assign vLast  = (vCount == vLastRow);
  assign actCol = (hCount >= hActStart);
  assign actRow = (vCount >= vActStart);
  assign preRow = (vCount == vActStart - 1'b1);

  // mirror mode fetches one line ahead of display
  assign fetchRow = flipEn ? (preRow || (actRow && !vLast)) : actRow;
  assign fetchOn  = !pwrSave && !testMode && actCol && fetchRow;
  assign fifoRd   = fetchOn;
  assign col      = hCount - hActStart;

  always_comb begin
    stb         = '0;
    stb.active  = actCol && actRow;
    stb.hRaw    = (hCount >= hFrontPorch) && (hCount < hSyncEnd);
    stb.vRaw    = (vCount >= vFrontPorch) && (vCount < vSyncEnd);
    stb.fetch   = fetchOn;
    stb.lineEnd = hLast && !pwrSave;
    stb.bar     = barIdx;
  end

  // raster position: reset lands on the first front-porch clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCount <= '0;
      vCount <= '0;
    end else if (!pwrSave) begin
      if (hLast) begin
        hCount <= '0;
        vCount <= vLast ? '0 : vCount + 1'b1;
      end else begin
        hCount <= hCount + 1'b1;
      end
    end
  end

  // bar tracker: leftover columns stay in the final bar
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      barCnt <= '0;
      barIdx <= '0;
    end else if (!pwrSave) begin
      if (!actCol || hLast) begin
        barCnt <= '0;
        barIdx <= '0;
      end else if ((barCnt == barWidth - 1'b1) &&
                   (barIdx != BAR_IDX_W'(BAR_COUNT - 1))) begin
        barCnt <= '0;
        barIdx <= barIdx + 1'b1;
      end else begin
        barCnt <= barCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/raster_data.sv
module raster_data
  import raster_pkg::*;
#(
  parameter int H_CNT_W  = 12,
  parameter int COMP_W   = 8,
  parameter int MAX_LINE = 1920
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwrSave,
  input  logic                testMode,
  input  logic                flipEn,
  input  logic                compSync,
  input  logic                hSyncPol,
  input  logic                vSyncPol,
  input  logic [H_CNT_W-1:0]  hVisible,
  input  strobe_t             stb,
  input  logic [H_CNT_W-1:0]  col,
  input  logic [3*COMP_W-1:0] fifoData,
  output logic [3*COMP_W-1:0] rgbOut,
  output logic                hSyncOut,
  output logic                vSyncOut,
  output logic                deOut
);

  localparam int PIX_W  = 3 * COMP_W;
  localparam int ADDR_W = $clog2(MAX_LINE);

  logic [PIX_W-1:0]   lineMem [2][MAX_LINE];
  logic               wrBank;
  logic [H_CNT_W-1:0] mirrorCol;
  logic [ADDR_W-1:0]  rdAddr, wrAddr;
  logic [2:0]         mask;
  logic [PIX_W-1:0]   barPix, pixNext;
  logic               hsNext, vsNext;

  assign mirrorCol = hVisible - 1'b1 - col;
  assign rdAddr    = mirrorCol[ADDR_W-1:0];
  assign wrAddr    = col[ADDR_W-1:0];
  assign mask      = barMask(stb.bar);
  assign barPix    = {{COMP_W{mask[2]}}, {COMP_W{mask[1]}}, {COMP_W{mask[0]}}};

  always_comb begin
    if (!stb.active)   pixNext = '0;
    else if (testMode) pixNext = barPix;
    else if (flipEn)   pixNext = lineMem[~wrBank][rdAddr];
    else               pixNext = fifoData;
  end

  assign hsNext = compSync ? ~(stb.hRaw ^ stb.vRaw)
                           : (hSyncPol ? stb.hRaw : ~stb.hRaw);
  assign vsNext = vSyncPol ? stb.vRaw : ~stb.vRaw;

  // two-bank line store: one bank fills while the other plays back
  always_ff @(posedge clk) begin
    if (stb.fetch && flipEn) lineMem[wrBank][wrAddr] <= fifoData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wrBank <= 1'b0;
    else if (stb.lineEnd) wrBank <= ~wrBank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgbOut   <= '0;
      hSyncOut <= 1'b0;
      vSyncOut <= 1'b0;
      deOut    <= 1'b0;
    end else if (pwrSave) begin
      rgbOut   <= '0;
      hSyncOut <= 1'b0;
      vSyncOut <= 1'b0;
      deOut    <= 1'b0;
    end else begin
      rgbOut   <= pixNext;
      hSyncOut <= hsNext;
      vSyncOut <= vsNext;
      deOut    <= stb.active;
    end
  end

endmodule

// File: rtl/raster_top.sv
module raster_top
  import raster_pkg::*;
#(
  parameter int H_CNT_W  = 12,
  parameter int V_CNT_W  = 12,
  parameter int COMP_W   = 8,
  parameter int MAX_LINE = 1920
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwrSave,
  input  logic                testMode,
  input  logic                flipEn,
  input  logic                compSync,
  input  logic                hSyncPol,
  input  logic                vSyncPol,
  input  logic [H_CNT_W-1:0]  hVisible,
  input  logic [H_CNT_W-1:0]  hFrontPorch,
  input  logic [H_CNT_W-1:0]  hSyncWidth,
  input  logic [H_CNT_W-1:0]  hBackPorch,
  input  logic [V_CNT_W-1:0]  vVisible,
  input  logic [V_CNT_W-1:0]  vFrontPorch,
  input  logic [V_CNT_W-1:0]  vSyncWidth,
  input  logic [V_CNT_W-1:0]  vBackPorch,
  output logic                fifoRd,
  input  logic [3*COMP_W-1:0] fifoData,
  output logic [3*COMP_W-1:0] rgbOut,
  output logic                hSyncOut,
  output logic                vSyncOut,
  output logic                deOut
);

  strobe_t            stb;
  logic [H_CNT_W-1:0] col;

  raster_ctrl #(.H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwrSave(pwrSave), .testMode(testMode),
    .flipEn(flipEn), .hVisible(hVisible), .hFrontPorch(hFrontPorch),
    .hSyncWidth(hSyncWidth), .hBackPorch(hBackPorch), .vVisible(vVisible),
    .vFrontPorch(vFrontPorch), .vSyncWidth(vSyncWidth),
    .vBackPorch(vBackPorch), .stb(stb), .col(col), .fifoRd(fifoRd)
  );

  raster_data #(.H_CNT_W(H_CNT_W), .COMP_W(COMP_W), .MAX_LINE(MAX_LINE)) u_data (
    .clk(clk), .rst_n(rst_n), .pwrSave(pwrSave), .testMode(testMode),
    .flipEn(flipEn), .compSync(compSync), .hSyncPol(hSyncPol),
    .vSyncPol(vSyncPol), .hVisible(hVisible), .stb(stb), .col(col),
    .fifoData(fifoData), .rgbOut(rgbOut), .hSyncOut(hSyncOut),
    .vSyncOut(vSyncOut), .deOut(deOut)
  );

endmodule

// File: rtl/raster_chk.sv
module raster_chk #(
  parameter int H_CNT_W = 12,
  parameter int V_CNT_W = 12,
  parameter int COMP_W  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pwrSave,
  input logic                testMode,
  input logic                flipEn,
  input logic                compSync,
  input logic                hSyncPol,
  input logic                vSyncPol,
  input logic [H_CNT_W-1:0]  hVisible,
  input logic [H_CNT_W-1:0]  hFrontPorch,
  input logic [H_CNT_W-1:0]  hSyncWidth,
  input logic [H_CNT_W-1:0]  hBackPorch,
  input logic [V_CNT_W-1:0]  vVisible,
  input logic [V_CNT_W-1:0]  vFrontPorch,
  input logic [V_CNT_W-1:0]  vSyncWidth,
  input logic [V_CNT_W-1:0]  vBackPorch,
  input logic                fifoRd,
  input logic [3*COMP_W-1:0] fifoData,
  input logic [3*COMP_W-1:0] rgbOut,
  input logic                hSyncOut,
  input logic                vSyncOut,
  input logic                deOut
);

  // R7
  test_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    testMode |-> !fifoRd);

  // R11
  save_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwrSave |-> !fifoRd);

  // R11
  save_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwrSave |=> (rgbOut == '0 && !deOut && !hSyncOut && !vSyncOut));

  // R4
  read_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoRd && !flipEn) |=> deOut);

  // R9
  blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !deOut |-> (rgbOut == '0));

endmodule

bind raster_top raster_chk #(.H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W), .COMP_W(COMP_W)) u_chk (.*);

// File: tb/tb_raster_top.sv
module tb_raster_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [23:0] rgb;
    logic        de;
    logic        hs;
    logic        vs;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrSave = 1'b0, testMode = 1'b0, flipEn = 1'b0, compSync = 1'b0;
  logic hSyncPol = 1'b1, vSyncPol = 1'b1;
  logic [11:0] hVisible, hFrontPorch, hSyncWidth, hBackPorch;
  logic [11:0] vVisible, vFrontPorch, vSyncWidth, vBackPorch;
  logic        fifoRd;
  logic [23:0] fifoData = '0;
  logic [23:0] rgbOut;
  logic        hSyncOut, vSyncOut, deOut;

  int hA, hF, hS, hB, vA, vF, vS, vB;
  int ch, cv, fr;
  int rdCount;
  logic prevRd;
  int total = 0, bad = 0;
  item_t expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  raster_top dut (
    .clk(clk), .rst_n(rst_n), .pwrSave(pwrSave), .testMode(testMode),
    .flipEn(flipEn), .compSync(compSync), .hSyncPol(hSyncPol),
    .vSyncPol(vSyncPol), .hVisible(hVisible), .hFrontPorch(hFrontPorch),
    .hSyncWidth(hSyncWidth), .hBackPorch(hBackPorch), .vVisible(vVisible),
    .vFrontPorch(vFrontPorch), .vSyncWidth(vSyncWidth),
    .vBackPorch(vBackPorch), .fifoRd(fifoRd), .fifoData(fifoData),
    .rgbOut(rgbOut), .hSyncOut(hSyncOut), .vSyncOut(vSyncOut), .deOut(deOut)
  );

  function automatic logic [23:0] pixf(input int k);
    logic [7:0] b;
    b = k[7:0];
    return {b, ~b, b ^ 8'h5A};
  endfunction

  function automatic logic [23:0] barColour(input int idx);
    case (idx)
      0: return 24'hFFFFFF;
      1: return 24'hFFFF00;
      2: return 24'h00FFFF;
      3: return 24'h00FF00;
      4: return 24'hFF00FF;
      5: return 24'hFF0000;
      6: return 24'h0000FF;
      default: return 24'h000000;
    endcase
  endfunction

  // show-ahead FIFO model: head word encodes its read index
  always begin
    @(negedge clk);
    #1;
    if (!rst_n) begin
      rdCount = 0;
      prevRd  = 1'b0;
    end else begin
      if (prevRd) rdCount++;
      prevRd = fifoRd;
    end
    fifoData = pixf(rdCount);
  end

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic setCfg(input int a, f, s, b, va, vf, vs, vb);
    hA = a; hF = f; hS = s; hB = b; vA = va; vF = vf; vS = vs; vB = vb;
    hVisible = 12'(a); hFrontPorch = 12'(f); hSyncWidth = 12'(s); hBackPorch = 12'(b);
    vVisible = 12'(va); vFrontPorch = 12'(vf); vSyncWidth = 12'(vs); vBackPorch = 12'(vb);
  endtask

  // expected output for raster position (h,v), computed from the requirements
  function automatic item_t expItem(input int h, input int v);
    item_t it;
    int hSA, vSA, c, r, bw, bi;
    logic hr, vr;
    hSA = hF + hS + hB;
    vSA = vF + vS + vB;
    hr = (h >= hF) && (h < hF + hS);
    vr = (v >= vF) && (v < vF + vS);
    it.de  = (h >= hSA) && (v >= vSA);
    it.hs  = compSync ? ~(hr ^ vr) : (hSyncPol ? hr : ~hr);
    it.vs  = vSyncPol ? vr : ~vr;
    it.rgb = '0;
    if (it.de) begin
      c = h - hSA;
      r = v - vSA;
      if (testMode) begin
        bw = hA / 8;
        bi = (bw == 0) ? 7 : c / bw;
        if (bi > 7) bi = 7;
        it.rgb = barColour(bi);
      end else if (flipEn) begin
        it.rgb = pixf(fr * hA * vA + r * hA + (hA - 1 - c));
      end else begin
        it.rgb = pixf(fr * hA * vA + r * hA + c);
      end
    end
    if (pwrSave) begin
      it.rgb = '0; it.de = 1'b0; it.hs = 1'b0; it.vs = 1'b0;
    end
    return it;
  endfunction

  function automatic logic expRd(input int h, input int v);
    int hSA, vSA;
    logic row;
    hSA = hF + hS + hB;
    vSA = vF + vS + vB;
    if (flipEn) row = (v == vSA - 1) || (v >= vSA && v < vSA + vA - 1);
    else        row = (v >= vSA);
    return !pwrSave && !testMode && (h >= hSA) && row;
  endfunction

  // driver pushes the expectation for this cycle; monitor pops it one edge later
  task automatic step();
    item_t e, got;
    string rq;
    #1;
    rq = pwrSave ? "R11" : (testMode ? "R7" : (flipEn ? "R8" : "R4"));
    chk({rq, " fifoRd"}, {23'd0, fifoRd}, {23'd0, expRd(ch, cv)});
    expQ.push_back(expItem(ch, cv));
    if (!pwrSave) begin
      if (ch == hF + hS + hB + hA - 1) begin
        ch = 0;
        if (cv == vF + vS + vB + vA - 1) begin
          cv = 0;
          fr++;
        end else cv++;
      end else ch++;
    end
    @(negedge clk);
    e = expQ.pop_front();
    got.de = deOut; got.hs = hSyncOut; got.vs = vSyncOut; got.rgb = rgbOut;
    chk(pwrSave ? "R11 de" : "R3 de", {23'd0, got.de}, {23'd0, e.de});
    chk(compSync ? "R6 hsync" : (hSyncPol ? "R1 hsync" : "R5 hsync"), {23'd0, got.hs}, {23'd0, e.hs});
    chk(vSyncPol ? "R2 vsync" : "R5 vsync", {23'd0, got.vs}, {23'd0, e.vs});
    if (!e.de) rq = "R9";
    chk({rq, " rgb"}, got.rgb, e.rgb);
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R10: everything low while reset is held
    chk("R10 rgb", rgbOut, 24'd0);
    chk("R10 flags", {20'd0, deOut, hSyncOut, vSyncOut, fifoRd}, 24'd0);
    expQ.delete();
    ch = 0; cv = 0; fr = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int frameLen();
    return (hA + hF + hS + hB) * (vA + vF + vS + vB);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired at t=%0t actual=running expected=done", $time);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 R2 R3 R4 R10: plain FIFO streaming, active-high syncs, two frames
    setCfg(16, 2, 3, 2, 4, 1, 2, 1);
    doReset();
    runCycles(2 * frameLen());

    // R5 R6: active-low vertical, composite on the horizontal pin
    hSyncPol = 1'b0; vSyncPol = 1'b0; compSync = 1'b1;
    doReset();
    runCycles(frameLen() + 30);

    // R5: separate syncs, both active-low
    compSync = 1'b0;
    doReset();
    runCycles(frameLen());
    hSyncPol = 1'b1; vSyncPol = 1'b1;

    // R7: colour bars with three leftover columns given to the last bar
    testMode = 1'b1;
    setCfg(19, 2, 3, 2, 3, 1, 1, 1);
    doReset();
    runCycles(frameLen() + 5);

    // R7: exact multiple of eight
    setCfg(16, 2, 3, 2, 3, 1, 1, 1);
    doReset();
    runCycles(frameLen());
    testMode = 1'b0;

    // R8: mirror mode, fetch one line ahead and reverse, two frames
    flipEn = 1'b1;
    setCfg(16, 2, 3, 2, 4, 1, 2, 1);
    doReset();
    runCycles(2 * frameLen() + 10);
    flipEn = 1'b0;

    // R11: power save in the middle of a visible line, then resume
    doReset();
    runCycles(100);
    pwrSave = 1'b1;
    runCycles(7);
    pwrSave = 1'b0;
    runCycles(frameLen());

    // R1 R2 R4: wider raster
    setCfg(40, 4, 5, 6, 6, 2, 2, 3);
    doReset();
    runCycles(frameLen() + 20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule